// File: doc/BRIEF.md
# Step Transition Watchdog Timer Bank

This block watches up to ten steps of a sequential controller. Each channel has an enable, a step-active flag, a transition-done flag and a 16-bit configuration word. The word holds a time limit in whole seconds and the fault number to raise. A channel arms when its step is active and it is enabled. If the transition that should end the step has not happened when the limit runs out, the channel raises a timeout. The bank turns each timeout into a one-cycle fault pulse. The pulse carries the configured fault number and the channel index, and it goes to an external fault table.

All channels share one seconds tick. A parameterised prescaler makes this tick from the system clock. Each channel is a small state machine with three states. In `CH_IDLE` the channel is disarmed. In `CH_RUN` it counts down seconds. In `CH_HOLD` it has fired or been satisfied, and it waits to be released. The transitions are ARM (`CH_IDLE` to `CH_RUN`), SATISFY-AT-ARM (`CH_IDLE` to `CH_HOLD`, taken when the transition is already done), EXPIRE and SATISFY (`CH_RUN` to `CH_HOLD`), ABORT (`CH_RUN` to `CH_IDLE`) and RELEASE (`CH_HOLD` to `CH_IDLE`). Timeouts that happen in the same cycle are held in a pending register and sent out one per cycle, lowest channel first.

Top module: `step_wdog_bank`

## Requirements
- R1: After reset `fault_valid` is low, and it stays low until some channel has timed out.
- R2: Configuration bits 15:8 hold the time limit in seconds, and bits 7:0 hold the fault number (0 to 255). A fault pulse shows that fault number on `fault_num` and the channel index on `fault_ch`.
- R3: A channel arms (ARM) on the clock edge where `ch_en` and `step_act` are both high, `trans_ok` is low and the limit N is not zero. On the N-th seconds tick after arming it expires. Its pulse appears two clock cycles after that tick. Counted from the first sampling point after the arming edge, the pulse falls in the window 3+(N-1)·D to 10+(N-1)·D cycles, where D is TICK_DIV and D=8. A timeout only ever happens in a tick cycle.
- R4: If `trans_ok` goes high before expiry, the timer stops and no pulse is issued (SATISFY).
- R5: If `step_act` or `ch_en` goes low before expiry, the timer clears and no pulse is issued (ABORT).
- R6: A channel whose limit field is zero never arms and never issues a pulse.
- R7: A channel issues at most one pulse per arming. After firing or being satisfied, it stays silent until `ch_en` or `step_act` has been low for at least one cycle (RELEASE). It can then arm again.
- R8: Timeouts that happen in the same cycle come out as pulses on consecutive cycles, in ascending channel order. Each pulse keeps its own fault number.
- R9: Each pulse lasts exactly one clock cycle for each timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NUM_CH | Per-channel watchdog enable |
| step_act | input | NUM_CH | Per-channel step-active flag |
| trans_ok | input | NUM_CH | Per-channel transition-done flag |
| cfg_word | input | NUM_CH*16 | Configuration words, channel i at bits [16i+15:16i] |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_num | output | 8 | Fault number carried by the pulse |
| fault_ch | output | CHW | Index of the channel that timed out |

## Verification
The checker watches several rules on every cycle:
- A timeout happens only in a tick cycle.
- No channel expires in the cycle after its enable or step flag was low.
- Every pulse comes from a non-empty pending set, and no lower channel was still pending when it was chosen.
- Consecutive pulses never repeat a channel.

Other behaviour can only be shown by the bench's directed scenarios:
- Pulse timing against the limit.
- The exact fault number carried.
- Silence after satisfy, abort and a zero limit.
- Single firing until release.
- The order and spacing of a triple timeout in one cycle.

// File: rtl/swd_pkg.sv
package swd_pkg;
    localparam int CFG_W  = 16;
    localparam int FNUM_W = 8;
    localparam int LIM_W  = 8;
    localparam int LIM_LSB = 8;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_HOLD = 2'd2
    } ch_state_t;
endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else begin
            if (div_cnt == LAST) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + CW'(1);
            end
            tick <= (div_cnt == LAST);
        end
    end
endmodule

// File: rtl/swd_channel.sv
module swd_channel
    import swd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              step,
    input  logic              trans,
    input  logic [CFG_W-1:0]  cfg,
    output logic              expire,
    output logic [FNUM_W-1:0] fnum
);
    ch_state_t          state, state_nx;
    logic [LIM_W-1:0]   secs_left;
    logic [LIM_W-1:0]   cfg_lim;
    logic               live;
    logic               last_sec;

    assign cfg_lim  = cfg[LIM_LSB +: LIM_W];
    assign live     = en & step;
    assign last_sec = (secs_left == LIM_W'(1));

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: begin
                if (live && (cfg_lim != '0)) begin
                    state_nx = trans ? CH_HOLD : CH_RUN;
                end
            end
            CH_RUN: begin
                if (!live) begin
                    state_nx = CH_IDLE;
                end else if (trans) begin
                    state_nx = CH_HOLD;
                end else if (tick && last_sec) begin
                    state_nx = CH_HOLD;
                end
            end
            CH_HOLD: begin
                if (!live) begin
                    state_nx = CH_IDLE;
                end
            end
            default: state_nx = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // countdown and captured fault number
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secs_left <= '0;
            fnum      <= '0;
        end else begin
            if (state == CH_IDLE && state_nx == CH_RUN) begin
                secs_left <= cfg_lim;
                fnum      <= cfg[FNUM_W-1:0];
            end else if (state == CH_RUN && tick && !last_sec) begin
                secs_left <= secs_left - LIM_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        expire = 1'b0;
        unique case (state)
            CH_RUN:  expire = live && !trans && tick && last_sec;
            CH_IDLE: expire = 1'b0;
            CH_HOLD: expire = 1'b0;
            default: expire = 1'b0;
        endcase
    end
endmodule

// File: rtl/swd_arbiter.sv
module swd_arbiter
    import swd_pkg::*;
#(
    parameter int NUM_CH = 10,
    parameter int CHW    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          expire,
    input  logic [NUM_CH*FNUM_W-1:0]   fnum_flat,
    output logic [NUM_CH-1:0]          pend_o,
    output logic                       valid_o,
    output logic [FNUM_W-1:0]          num_o,
    output logic [CHW-1:0]             ch_o
);
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] grant;
    logic [CHW-1:0]    sel;
    logic [FNUM_W-1:0] pnum [NUM_CH];

    assign pend_o = pend;
    assign grant  = pend & (~pend + NUM_CH'(1));

    always_comb begin
        sel = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                sel = CHW'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= '0;
            valid_o <= 1'b0;
            num_o   <= '0;
            ch_o    <= '0;
        end else begin
            pend    <= (pend & ~grant) | expire;
            valid_o <= |pend;
            num_o   <= pnum[sel];
            ch_o    <= sel;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pnum
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pnum[g] <= '0;
            end else if (expire[g]) begin
                pnum[g] <= fnum_flat[g*FNUM_W +: FNUM_W];
            end
        end
    end
endmodule

// File: rtl/step_wdog_bank.sv
module step_wdog_bank
    import swd_pkg::*;
#(
    parameter int NUM_CH   = 10,
    parameter int TICK_DIV = 50_000_000,
    localparam int CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH-1:0]       step_act,
    input  logic [NUM_CH-1:0]       trans_ok,
    input  logic [NUM_CH*CFG_W-1:0] cfg_word,
    output logic                    fault_valid,
    output logic [FNUM_W-1:0]       fault_num,
    output logic [CHW-1:0]          fault_ch
);
    logic                      tick;
    logic [NUM_CH-1:0]         expire;
    logic [NUM_CH-1:0]         pend;
    logic [NUM_CH*FNUM_W-1:0]  fnum_flat;

    swd_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        swd_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .en     (ch_en[g]),
            .step   (step_act[g]),
            .trans  (trans_ok[g]),
            .cfg    (cfg_word[g*CFG_W +: CFG_W]),
            .expire (expire[g]),
            .fnum   (fnum_flat[g*FNUM_W +: FNUM_W])
        );
    end

    swd_arbiter #(.NUM_CH(NUM_CH), .CHW(CHW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .fnum_flat (fnum_flat),
        .pend_o    (pend),
        .valid_o   (fault_valid),
        .num_o     (fault_num),
        .ch_o      (fault_ch)
    );
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
    parameter int NUM_CH = 10,
    parameter int CHW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [NUM_CH-1:0] expire,
    input logic [NUM_CH-1:0] pend,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] step_act,
    input logic              fault_valid,
    input logic [CHW-1:0]    fault_ch
);
    logic [NUM_CH-1:0] below_mask;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            below_mask[i] = (32'(i) < 32'(fault_ch));
        end
    end

    // R3
    expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire != '0) |-> tick);

    // R5
    no_expire_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((expire & ~$past(ch_en)) == '0) && ((expire & ~$past(step_act)) == '0));

    // R1
    pulse_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> ($past(pend) != '0));

    // R8
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> ((($past(pend) & below_mask) == '0) && (32'(fault_ch) < NUM_CH)));

    // R9
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && $past(fault_valid)) |-> (fault_ch != $past(fault_ch)));
endmodule

bind step_wdog_bank swd_checker #(.NUM_CH(NUM_CH), .CHW(CHW)) u_swd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .expire      (expire),
    .pend        (pend),
    .ch_en       (ch_en),
    .step_act    (step_act),
    .fault_valid (fault_valid),
    .fault_ch    (fault_ch)
);

// File: tb/step_wdog_bank_bench.sv
module step_wdog_bank_bench;
    localparam int NCH = 10;
    localparam int DIV = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  ch_en = '0;
    logic [NCH-1:0]  step_act = '0;
    logic [NCH-1:0]  trans_ok = '0;
    logic [NCH*16-1:0] cfg_word = '0;
    logic            fault_valid;
    logic [7:0]      fault_num;
    logic [3:0]      fault_ch;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    step_wdog_bank #(.NUM_CH(NCH), .TICK_DIV(DIV)) u_step_wdog_bank (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .step_act(step_act),
        .trans_ok(trans_ok), .cfg_word(cfg_word),
        .fault_valid(fault_valid), .fault_num(fault_num), .fault_ch(fault_ch)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog all-reqs actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string detail);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s", req, detail);
        end
    endtask

    task automatic set_cfg(input int ch, input int lim, input int fn);
        cfg_word[ch*16 +: 16] = {8'(lim), 8'(fn)};
    endtask

    // Waits up to max_cyc negedges for a pulse; n = index of the negedge where seen.
    task automatic wait_pulse(input int max_cyc, output bit got, output int n);
        got = 1'b0;
        n = 0;
        for (int k = 1; k <= max_cyc; k++) begin
            @(negedge clk);
            if (fault_valid) begin
                got = 1'b1;
                n = k;
                break;
            end
        end
    endtask

    task automatic count_pulses(input int ncyc, output int cnt);
        cnt = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (fault_valid) cnt++;
        end
    endtask

    task automatic idle_all();
        @(negedge clk);
        ch_en = '0; step_act = '0; trans_ok = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        int cnt;
        count_pulses(20, cnt);
        chk(cnt == 0, "R1", $sformatf("pulses after reset actual=%0d expected=0", cnt));
    endtask

    task automatic t_single();
        bit got; int n; int lo; int hi; int cnt;
        set_cfg(3, 2, 8'hA5);
        @(negedge clk);
        ch_en[3] = 1'b1; step_act[3] = 1'b1;
        lo = 3 + DIV; hi = 10 + DIV;
        wait_pulse(60, got, n);
        chk(got, "R3", $sformatf("pulse seen actual=%0d expected=1", got));
        chk(n >= lo && n <= hi, "R3", $sformatf("latency actual=%0d expected=%0d..%0d", n, lo, hi));
        chk(fault_num == 8'hA5, "R2", $sformatf("fault_num actual=%0h expected=a5", fault_num));
        chk(fault_ch == 4'd3, "R2", $sformatf("fault_ch actual=%0d expected=3", fault_ch));
        @(negedge clk);
        chk(!fault_valid, "R9", $sformatf("pulse width actual=%0d expected=0 next cycle", fault_valid));
        count_pulses(5 * DIV, cnt);
        chk(cnt == 0, "R7", $sformatf("repeat pulses while armed actual=%0d expected=0", cnt));
        ch_en[3] = 1'b0;
        @(negedge clk);
        set_cfg(3, 1, 8'h3C);
        ch_en[3] = 1'b1;
        wait_pulse(30, got, n);
        chk(got && fault_num == 8'h3C, "R7",
            $sformatf("re-arm pulse actual=%0d/%0h expected=1/3c", got, fault_num));
        chk(n >= 3 && n <= 10, "R3", $sformatf("1s latency actual=%0d expected=3..10", n));
        idle_all();
    endtask

    task automatic t_satisfy();
        int cnt;
        set_cfg(0, 3, 8'h11);
        @(negedge clk);
        ch_en[0] = 1'b1; step_act[0] = 1'b1;
        repeat (10) @(negedge clk);
        trans_ok[0] = 1'b1;
        count_pulses(6 * DIV, cnt);
        chk(cnt == 0, "R4", $sformatf("pulses after transition actual=%0d expected=0", cnt));
        trans_ok[0] = 1'b0;
        count_pulses(6 * DIV, cnt);
        chk(cnt == 0, "R7", $sformatf("pulses before release actual=%0d expected=0", cnt));
        idle_all();
    endtask

    task automatic t_abort();
        int cnt;
        set_cfg(6, 2, 8'h22);
        set_cfg(8, 2, 8'h33);
        @(negedge clk);
        ch_en[6] = 1'b1; step_act[6] = 1'b1;
        ch_en[8] = 1'b1; step_act[8] = 1'b1;
        repeat (6) @(negedge clk);
        step_act[6] = 1'b0;
        ch_en[8] = 1'b0;
        count_pulses(6 * DIV, cnt);
        chk(cnt == 0, "R5", $sformatf("pulses after step/enable drop actual=%0d expected=0", cnt));
        idle_all();
    endtask

    task automatic t_zero();
        int cnt;
        set_cfg(4, 0, 8'h44);
        @(negedge clk);
        ch_en[4] = 1'b1; step_act[4] = 1'b1;
        count_pulses(8 * DIV, cnt);
        chk(cnt == 0, "R6", $sformatf("pulses with zero limit actual=%0d expected=0", cnt));
        idle_all();
    endtask

    task automatic t_simul();
        bit got; int n;
        set_cfg(7, 1, 8'h77);
        set_cfg(2, 1, 8'h02);
        set_cfg(5, 1, 8'hF5);
        @(negedge clk);
        ch_en[7] = 1'b1; step_act[7] = 1'b1;
        ch_en[2] = 1'b1; step_act[2] = 1'b1;
        ch_en[5] = 1'b1; step_act[5] = 1'b1;
        wait_pulse(30, got, n);
        chk(got && fault_ch == 4'd2 && fault_num == 8'h02, "R8",
            $sformatf("first actual=%0d/%0h expected=2/02", fault_ch, fault_num));
        @(negedge clk);
        chk(fault_valid && fault_ch == 4'd5 && fault_num == 8'hF5, "R8",
            $sformatf("second actual=%0d/%0d/%0h expected=1/5/f5", fault_valid, fault_ch, fault_num));
        @(negedge clk);
        chk(fault_valid && fault_ch == 4'd7 && fault_num == 8'h77, "R8",
            $sformatf("third actual=%0d/%0d/%0h expected=1/7/77", fault_valid, fault_ch, fault_num));
        @(negedge clk);
        chk(!fault_valid, "R9", $sformatf("after burst actual=%0d expected=0", fault_valid));
        idle_all();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_satisfy();
        t_abort();
        t_zero();
        t_simul();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule